// File: doc/BRIEF.md
# Grouped Pulse Time-Stamp Capture Unit

This block records when pulses arrive on a bank of inputs. A shared free-running binary time base advances at a slow tick rate derived from the system clock. Each pulse input has its own capture register. The first rising edge seen on an armed input stores the current time-base value in that input's register.

Inputs are organised in groups of four consecutive channels, and each group records one physical event. Once every channel of a group has captured, the group's done flag goes high. An interrupt line then rises for every group whose enable bit is set. Host software reads the stamps through a small word-addressed register port and takes differences modulo the counter range. It then writes a one to the group's bit in a re-arm register, which prepares the group for the next event.

Channel c belongs to group c/4. Word address c (c < channel count) reads channel c's stamp, zero-extended. The address just past the last channel reads the done flags, the next address holds the interrupt enable mask, and the one after that is the re-arm register.

Top module: `tscap_top`

## Requirements
- R1: The time base starts at zero after reset and advances by exactly one every TICK_DIV clock cycles, wrapping modulo 2^STAMP_W; the difference between two stamps taken an exact multiple of TICK_DIV cycles apart equals that multiple.
- R2: Each pulse input passes through two synchroniser flops and a rising-edge detector; a rising edge on an armed channel stores the time-base value into that channel, readable at word address c with zeros above bit STAMP_W-1.
- R3: A channel captures only its first rising edge after being armed; later edges leave its stamp unchanged until its group is re-armed.
- R4: Bit g of the word at address NCH (NCH = channel count) is set once all four channels 4g..4g+3 have captured, and stays set until group g is re-armed.
- R5: The word at address NCH+1 is a read/write enable mask (bit g for group g, reset 0); irq_o is high exactly when some group has both its done bit and its mask bit set.
- R6: Writing to address NCH+2 re-arms every group whose data bit is 1 and clears its done bit; bits written as 0 have no effect, and stored stamps keep their values until recaptured.
- R7: When a re-arm write and a captured rising edge of the same group occur in the same cycle, the re-arm wins and that edge is lost.
- R8: Reads are registered: rd_data_o shows, one cycle later, the word selected by rd_addr_i; address NCH+2 and every address above it read as zero.
- R9: After reset all stamps, done flags, mask bits, irq_o and rd_data_o are zero and every channel is armed.
- R10: For two captures of one group with fewer than 2^STAMP_W ticks between them, (later - earlier) mod 2^STAMP_W gives the interval even when the time base wraps in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_i | input | GROUPS*GRP_CH | Asynchronous pulse inputs, one per channel |
| rd_addr_i | input | ADDR_W | Word address for reads |
| rd_data_o | output | BUS_W | Registered read data |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | ADDR_W | Word address for writes |
| wr_data_i | input | BUS_W | Write data |
| irq_o | output | 1 | Interrupt: some enabled group is complete |

## Verification
The bench builds the block with ten groups of four, an 8-bit time base and a tick every second clock. The narrow counter wraps every 512 cycles, so an interval that straddles a wrap can be produced in a short run. The two-cycle tick still keeps the prescaler on a real divide path. The full 40-channel address map stays in place, so the done, mask and re-arm addresses and the unmapped range above them are all exercised. A same-cycle collision between a re-arm write and an edge arriving through the synchroniser is also set up on purpose.

// File: rtl/tscap_pkg.sv
package tscap_pkg;

    // Source selected for the registered read port
    typedef enum logic [1:0] {
        RSEL_STAMP,
        RSEL_DONE,
        RSEL_MASK,
        RSEL_ZERO
    } rsel_e;

endpackage

// File: rtl/tscap_timebase.sv
module tscap_timebase #(
    parameter int STAMP_W  = 24,
    parameter int TICK_DIV = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [STAMP_W-1:0] count_o
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    typedef struct packed {
        logic [PW-1:0]      pre;
        logic [STAMP_W-1:0] cnt;
    } tb_t;

    tb_t  d, q;
    logic tick;

    assign tick = (q.pre == PW'(TICK_DIV - 1));

    always_comb begin
        d = q;
        if (tick) begin
            d.pre = '0;
            d.cnt = q.cnt + 1'b1;
        end else begin
            d.pre = q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign count_o = q.cnt;

    // R1: one step per tick, wrapping naturally
    a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> count_o == STAMP_W'($past(count_o) + 1'b1));
    // R1: no movement between ticks
    a_r1_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count_o));

endmodule

// File: rtl/tscap_sync.sv
module tscap_sync #(
    parameter int WIDTH = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] rise_o
);
    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
        logic [WIDTH-1:0] s3;
    } sy_t;

    sy_t d, q;

    always_comb begin
        d    = q;
        d.s1 = async_i;
        d.s2 = q.s1;
        d.s3 = q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rise_o = q.s2 & ~q.s3;

    // R2: an edge indication never lasts two cycles on one channel
    a_r2_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise_o) |=> ((rise_o & $past(rise_o)) == '0));

endmodule

// File: rtl/tscap_group.sv
module tscap_group #(
    parameter int LANES   = 4,
    parameter int STAMP_W = 24
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [LANES-1:0]                rise_i,
    input  logic                            clear_i,
    input  logic [STAMP_W-1:0]              count_i,
    output logic [LANES-1:0][STAMP_W-1:0]   stamp_o,
    output logic                            done_o
);
    typedef struct packed {
        logic [LANES-1:0]              cap;
        logic [LANES-1:0][STAMP_W-1:0] stamp;
    } grp_t;

    grp_t d, q;

    always_comb begin
        d = q;
        for (int i = 0; i < LANES; i++) begin
            if (clear_i) begin
                d.cap[i] = 1'b0;
            end else if (rise_i[i] && !q.cap[i]) begin
                d.cap[i]   = 1'b1;
                d.stamp[i] = count_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign stamp_o = q.stamp;
    assign done_o  = &q.cap;

    for (genvar i = 0; i < LANES; i++) begin : g_lane_chk
        // R2: armed lane latches the time base seen at the edge
        a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
            (rise_i[i] && !q.cap[i] && !clear_i) |=> stamp_o[i] == $past(count_i));
        // R3: a captured lane keeps its stamp
        a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (q.cap[i] && !clear_i) |=> $stable(stamp_o[i]));
    end

    // R4: completion persists until re-armed
    a_r4_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !clear_i) |=> done_o);
    // R6, R7: re-arm empties the group even against a same-cycle edge
    a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (q.cap == '0 && !done_o));

endmodule

// File: rtl/tscap_top.sv
module tscap_top
    import tscap_pkg::*;
#(
    parameter int GROUPS   = 10,
    parameter int GRP_CH   = 4,
    parameter int STAMP_W  = 24,
    parameter int TICK_DIV = 20,
    parameter int BUS_W    = 32,
    parameter int ADDR_W   = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [GROUPS*GRP_CH-1:0]   pulse_i,
    input  logic [ADDR_W-1:0]          rd_addr_i,
    output logic [BUS_W-1:0]           rd_data_o,
    input  logic                       wr_en_i,
    input  logic [ADDR_W-1:0]          wr_addr_i,
    input  logic [BUS_W-1:0]           wr_data_i,
    output logic                       irq_o
);
    localparam int NCH    = GROUPS * GRP_CH;
    localparam int IDX_W  = $clog2(NCH);
    localparam int A_DONE = NCH;
    localparam int A_MASK = NCH + 1;
    localparam int A_CLR  = NCH + 2;

    typedef struct packed {
        logic [GROUPS-1:0] mask;
        logic [BUS_W-1:0]  rd;
    } regs_t;

    regs_t                          d, q;
    rsel_e                          sel;
    logic [STAMP_W-1:0]             count;
    logic [NCH-1:0]                 rise;
    logic [GROUPS-1:0]              done;
    logic [GROUPS-1:0]              clr;
    logic [NCH-1:0][STAMP_W-1:0]    stamp_all;
    logic [IDX_W-1:0]               idx;

    tscap_timebase #(
        .STAMP_W  (STAMP_W),
        .TICK_DIV (TICK_DIV)
    ) u_timebase (
        .clk     (clk),
        .rst_n   (rst_n),
        .count_o (count)
    );

    tscap_sync #(
        .WIDTH (NCH)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pulse_i),
        .rise_o  (rise)
    );

    assign clr = (wr_en_i && wr_addr_i == ADDR_W'(A_CLR)) ? wr_data_i[GROUPS-1:0] : '0;

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        tscap_group #(
            .LANES   (GRP_CH),
            .STAMP_W (STAMP_W)
        ) u_group (
            .clk     (clk),
            .rst_n   (rst_n),
            .rise_i  (rise[g*GRP_CH +: GRP_CH]),
            .clear_i (clr[g]),
            .count_i (count),
            .stamp_o (stamp_all[g*GRP_CH +: GRP_CH]),
            .done_o  (done[g])
        );
    end

    assign idx = IDX_W'(rd_addr_i);

    always_comb begin
        if (rd_addr_i < ADDR_W'(NCH))          sel = RSEL_STAMP;
        else if (rd_addr_i == ADDR_W'(A_DONE)) sel = RSEL_DONE;
        else if (rd_addr_i == ADDR_W'(A_MASK)) sel = RSEL_MASK;
        else                                   sel = RSEL_ZERO;
    end

    always_comb begin
        d = q;
        if (wr_en_i && wr_addr_i == ADDR_W'(A_MASK))
            d.mask = wr_data_i[GROUPS-1:0];
        case (sel)
            RSEL_STAMP: d.rd = BUS_W'(stamp_all[idx]);
            RSEL_DONE:  d.rd = BUS_W'(done);
            RSEL_MASK:  d.rd = BUS_W'(q.mask);
            default:    d.rd = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_data_o = q.rd;
    assign irq_o     = |(done & q.mask);

    // R8: addresses from the re-arm register upward read as zero
    a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_i >= ADDR_W'(A_CLR)) |=> rd_data_o == '0);
    // R5: a mask write takes effect on the next cycle
    a_r5_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == ADDR_W'(A_MASK)) |=> q.mask == $past(wr_data_i[GROUPS-1:0]));
    // R5: with an all-zero mask no interrupt is raised
    a_r5_mask_gates: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mask == '0) |-> !irq_o);

endmodule

// File: tb/tscap_top_tb.sv
`timescale 1ns/1ps
module tscap_top_tb;
    localparam int GROUPS = 10;
    localparam int GRP_CH = 4;
    localparam int STW    = 8;
    localparam int DIV    = 2;
    localparam int NCH    = GROUPS * GRP_CH;
    localparam int MOD    = 1 << STW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH-1:0]    pulse = '0;
    logic [5:0]        rd_addr = '0;
    logic [31:0]       rd_data;
    logic              wr_en = 1'b0;
    logic [5:0]        wr_addr = '0;
    logic [31:0]       wr_data = '0;
    logic              irq;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    tscap_top #(
        .GROUPS(GROUPS), .GRP_CH(GRP_CH), .STAMP_W(STW),
        .TICK_DIV(DIV), .BUS_W(32), .ADDR_W(6)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .pulse_i(pulse),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .irq_o(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int          m_stamp [NCH];
    bit          m_cap   [NCH];
    bit          m_s1 [NCH];
    bit          m_s2 [NCH];
    bit          m_s3 [NCH];
    int          m_cnt, m_pre;
    bit [9:0]    m_mask;
    logic [31:0] m_rd;

    function automatic bit [9:0] m_done();
        bit [9:0] r = '0;
        for (int g = 0; g < GROUPS; g++) begin
            bit all = 1;
            for (int k = 0; k < GRP_CH; k++) all &= m_cap[g*GRP_CH + k];
            r[g] = all;
        end
        return r;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                m_stamp[c] = 0; m_cap[c] = 0; m_s1[c] = 0; m_s2[c] = 0; m_s3[c] = 0;
            end
            m_cnt = 0; m_pre = 0; m_mask = '0; m_rd = '0;
        end else begin
            int a;
            bit [9:0] clrv;
            a = int'(rd_addr);
            if (a < NCH)          m_rd = 32'(m_stamp[a]);
            else if (a == NCH)    m_rd = 32'(m_done());
            else if (a == NCH+1)  m_rd = 32'(m_mask);
            else                  m_rd = '0;
            clrv = (wr_en && int'(wr_addr) == NCH+2) ? wr_data[9:0] : '0;
            for (int c = 0; c < NCH; c++) begin
                if (clrv[c/GRP_CH]) m_cap[c] = 0;
                else if (m_s2[c] && !m_s3[c] && !m_cap[c]) begin
                    m_stamp[c] = m_cnt; m_cap[c] = 1;
                end
            end
            if (wr_en && int'(wr_addr) == NCH+1) m_mask = wr_data[9:0];
            if (m_pre == DIV-1) begin m_pre = 0; m_cnt = (m_cnt + 1) % MOD; end
            else m_pre++;
            for (int c = 0; c < NCH; c++) begin
                m_s3[c] = m_s2[c]; m_s2[c] = m_s1[c]; m_s1[c] = pulse[c];
            end
        end
        #1;
        if (!finished) begin
            chk("R8 per-cycle read data", rd_data, m_rd);
            chk("R5 per-cycle irq", {31'b0, irq}, {31'b0, |(m_done() & m_mask)});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic rd(input int addr, output logic [31:0] v);
        @(negedge clk) rd_addr = 6'(addr);
        @(posedge clk); #2;
        v = rd_data;
    endtask

    task automatic wr(input int addr, input logic [31:0] v);
        @(negedge clk) begin wr_en = 1'b1; wr_addr = 6'(addr); wr_data = v; end
        @(negedge clk) wr_en = 1'b0;
    endtask

    task automatic fire(input int c);
        @(negedge clk) pulse[c] = 1'b1;
        repeat (3) @(negedge clk);
        pulse[c] = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (120000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        logic [31:0] v, s0, s1v;
        int t0, dd;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R9: reset state
        rd(NCH, v);   chk("R9 done flags after reset", v, 32'h0);
        rd(NCH+1, v); chk("R9 mask after reset", v, 32'h0);
        rd(5, v);     chk("R9 stamp after reset", v, 32'h0);
        chk("R9 irq after reset", {31'b0, irq}, 32'h0);

        // R1 / R2: interval between two captures, 37 ticks apart
        @(negedge clk) pulse[8] = 1'b1; t0 = cyc;
        idle(3); pulse[8] = 1'b0;
        while (cyc != t0 + 37*DIV) @(negedge clk);
        pulse[9] = 1'b1; idle(3); pulse[9] = 1'b0;
        idle(3);
        rd(8, s0); rd(9, s1v);
        chk("R1 tick interval", (s1v - s0) & (MOD-1), 32'd37);
        chk("R2 upper bits zero", s1v & ~32'(MOD-1), 32'h0);
        rd(NCH, v); chk("R4 partial group not done", v, 32'h0);

        // R4 / R5: complete group 2 with its interrupt enabled
        wr(NCH+1, 32'h4);
        fire(10); idle(3);
        chk("R5 irq low before group full", {31'b0, irq}, 32'h0);
        fire(11); idle(3);
        rd(NCH, v); chk("R4 group 2 done", v, 32'h4);
        chk("R5 irq with enabled done group", {31'b0, irq}, 32'h1);
        wr(NCH+1, 32'h0); idle(1);
        chk("R5 irq masked off", {31'b0, irq}, 32'h0);
        rd(NCH+1, v); chk("R5 mask readback", v, 32'h0);
        wr(NCH+1, 32'h3FF);

        // R3: second edge ignored
        fire(8); idle(4);
        rd(8, v); chk("R3 later edge ignored", v, s0);

        // R6: zero bits do nothing, one bits re-arm, stamps retained
        wr(NCH+2, 32'h0); idle(1);
        rd(NCH, v); chk("R6 zero write keeps done", v, 32'h4);
        wr(NCH+2, 32'h24); idle(1);
        rd(NCH, v); chk("R6 re-arm clears done", v, 32'h0);
        chk("R6 irq drops after re-arm", {31'b0, irq}, 32'h0);
        rd(9, v); chk("R6 stamp retained", v, s1v);

        // R7: re-arm in the same cycle as the capture of ch12
        @(negedge clk) pulse[12] = 1'b1;
        @(negedge clk);
        @(negedge clk) begin wr_en = 1'b1; wr_addr = 6'(NCH+2); wr_data = 32'h8; end
        @(negedge clk) wr_en = 1'b0;
        fire(13); fire(14); fire(15); idle(4);
        rd(NCH, v); chk("R7 colliding edge lost", v, 32'h0);
        rd(12, v);  chk("R7 no stamp taken", v, 32'h0);
        @(negedge clk) pulse[12] = 1'b0;
        idle(3);
        fire(12); idle(4);
        rd(NCH, v); chk("R7 group completes on later edge", v, 32'h8);

        // R10: interval spanning a wrap of the time base
        @(negedge clk) pulse[0] = 1'b1; t0 = cyc;
        idle(3); pulse[0] = 1'b0;
        idle(3);
        rd(0, s0);
        dd = 255 - int'(s0) / 2;
        while (cyc != t0 + dd*DIV) @(negedge clk);
        pulse[1] = 1'b1; idle(3); pulse[1] = 1'b0;
        idle(3);
        rd(1, s1v);
        chk("R10 modular interval", (s1v - s0) & (MOD-1), 32'(dd));
        chk("R10 wrap occurred", {31'b0, (s0 >= 2) ? (s1v < s0) : 1'b1}, 32'h1);

        // R8: write-only and unmapped addresses read zero
        rd(NCH+2, v); chk("R8 re-arm address reads zero", v, 32'h0);
        rd(63, v);    chk("R8 unmapped reads zero", v, 32'h0);

        idle(2);
        summary();
    end

endmodule